// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block is the control state machine of a superscalar rename stage. Each cycle decode offers a group of up to `W` instruction slots. For every slot it gives a squashed flag and a count of destination registers. The controller decides which slots go on toward issue in this cycle and drives a per-slot dispatch mask. The decision takes account of reorder-buffer credit, issue-queue credit and free physical registers. The map lookups themselves sit outside the block.

Downstream credit counts arrive `DELAY` cycles late. The controller therefore subtracts `W*DELAY` from each reported count before it uses it. When the stage cannot finish a group, it parks that group in a skid buffer that holds whole groups and records the slot at which it stopped. It then raises a stall toward decode. When the blocking conditions clear, it replays the parked groups, beginning at the recorded slot. A squash request, or an indication that the reorder buffer is squashing, empties the skid buffer. The controller then waits in a squash state until both signals go low.

States and transitions: Idle (after reset; moves to Running when the first group is handled), Running (Idle/Running -> Blocked on a stall input, on no credit or on a partial group; -> Squashing on squash), Blocked (-> Unblocking once the way is clear and groups are parked, -> Running once the way is clear and nothing is parked, -> Squashing on squash), Unblocking (-> Running when the last parked group drains, -> Blocked if the replay stops again, -> Squashing on squash), Squashing (-> Running when both squash inputs are low).

Top module: `rename_flow_ctrl`

## Requirements
- R1: After reset `state` is Idle and `stall_up` and `dispatch_mask` are zero. The state codes are Idle=0, Running=1, Blocked=2, Unblocking=3 and Squashing=4. In Idle with an empty group (`grp_cnt`=0) the state stays Idle.
- R2: In Idle or Running with enough resources, mask bit j is set for each unsquashed slot j < `grp_cnt`. At the next edge the state becomes Running. Slot j's destination count is `grp_dst[j*DST_W +: DST_W]`.
- R3: Usable credit is the free count minus W*DELAY, computed separately for the ROB and the IQ. If the smaller of the two is zero or below, the mask is zero and the next state is Blocked.
- R4: If the credit covers fewer unsquashed slots than the group offers, only the first `credit` unsquashed slots are dispatched. The next state is Blocked, and the group is parked with the index of the first slot not dispatched.
- R5: A slot whose `grp_squashed` bit is set is never dispatched. It uses no credit.
- R6: The walk stops at the first unsquashed slot whose destination count exceeds the physical registers still free (the free count less those used by earlier slots in the same cycle). The next state is Blocked.
- R7: While Blocked, the mask is zero and every non-empty incoming group is parked. `stall_up` is high in Blocked and in Unblocking, and low in every other state.
- R8: Blocked is left only when both stall inputs are low, both usable credits are positive and `preg_free` is non-zero. The next state is then Unblocking if groups are parked, else Running.
- R9: In Unblocking the head parked group is walked from the saved slot index. When the head completes it is removed and the index returns to 0. The state returns to Running once the buffer is empty and no new group arrives.
- R10: `squash_req` or `rob_squashing` in Idle, Running, Blocked or Unblocking empties the skid buffer, clears the saved index and zeroes the mask. The next state is Squashing. Squashing holds while either input is high and moves to Running the cycle after both are low.
- R11: `skid_ovf` is high in a cycle where a group must be parked, the skid buffer is full and nothing is removed. That group is dropped.
- R12: `iew_stall` or `cmt_stall` in Idle, Running or Unblocking zeroes the mask. The next state is Blocked, and any non-empty incoming group is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_cnt | input | $clog2(W+1) | Number of valid slots in the incoming group |
| grp_squashed | input | W | Per-slot squashed flag |
| grp_dst | input | W*DST_W | Per-slot destination register count |
| rob_free | input | CRED_W | Reported free ROB entries (delayed) |
| iq_free | input | CRED_W | Reported free IQ entries (delayed) |
| preg_free | input | PREG_W | Free physical registers |
| iew_stall | input | 1 | Stall from execute |
| cmt_stall | input | 1 | Stall from commit |
| squash_req | input | 1 | Squash from commit |
| rob_squashing | input | 1 | ROB still squashing |
| dispatch_mask | output | W | Slots dispatched this cycle |
| stall_up | output | 1 | Stall toward decode |
| state | output | 3 | Current controller state |
| skid_ovf | output | 1 | Skid buffer overflow, group dropped |

## Verification
A wrong saved slot index shows up in the first replay cycle after Unblocking is entered: the mask starts at the wrong bit. A skid buffer that was not flushed shows up when a later Blocked exit goes to Unblocking instead of Running, one edge after the way clears. Wrong credit arithmetic changes the mask in the same cycle the group is offered. The directed scenarios therefore sit right at the boundaries: zero usable credit, exactly one usable credit, and a register shortfall part-way through a group.

// File: rtl/rename_flow_pkg.sv
package rename_flow_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCK   = 3'd2,
        ST_UNBLOCK = 3'd3,
        ST_SQUASH  = 3'd4
    } rn_state_e;
endpackage

// File: rtl/rn_skid_fifo.sv
module rn_skid_fifo #(
    parameter int GW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [GW-1:0] din,
    output logic [GW-1:0] dout,
    output logic          empty,
    output logic          last,
    output logic          ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [GW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [LVL_W-1:0] lvl_q;
    logic             full, do_push, do_pop;

    assign full    = (lvl_q == LVL_W'(DEPTH));
    assign empty   = (lvl_q == '0);
    assign last    = (lvl_q == LVL_W'(1));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign ovf     = push && full && !do_pop && !flush;
    assign dout    = mem[rd_q];

    function automatic logic [PTR_W-1:0] nxt_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) begin
                mem[wr_q] <= din;
                wr_q      <= nxt_ptr(wr_q);
            end
            if (do_pop) rd_q <= nxt_ptr(rd_q);
            lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end
endmodule

// File: rtl/rn_slot_walker.sv
module rn_slot_walker #(
    parameter int W      = 4,
    parameter int CNT_W  = 3,
    parameter int DST_W  = 2,
    parameter int CRW    = 10,
    parameter int PREG_W = 8
) (
    input  logic [CNT_W-1:0]      start_idx,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [W-1:0]          squashed,
    input  logic [W*DST_W-1:0]    dst,
    input  logic signed [CRW-1:0] credit,
    input  logic [PREG_W-1:0]     preg,
    output logic [W-1:0]          mask,
    output logic                  short_stop,
    output logic [CNT_W-1:0]      stop_idx
);
    always_comb begin
        logic signed [CRW-1:0] left;
        logic [PREG_W:0]       pleft;
        logic [PREG_W:0]       need;
        mask       = '0;
        short_stop = 1'b0;
        stop_idx   = '0;
        left       = credit;
        pleft      = (PREG_W + 1)'(preg);
        for (int j = 0; j < W; j++) begin
            need = (PREG_W + 1)'(dst[j*DST_W +: DST_W]);
            if (!short_stop && j >= int'(start_idx) && j < int'(cnt) && !squashed[j]) begin
                if (left <= 0 || need > pleft) begin
                    short_stop = 1'b1;
                    stop_idx   = CNT_W'(j);
                end else begin
                    mask[j] = 1'b1;
                    left    = left - CRW'(1);
                    pleft   = pleft - need;
                end
            end
        end
    end
endmodule

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl
    import rename_flow_pkg::*;
#(
    parameter int W      = 4,
    parameter int DELAY  = 1,
    parameter int DST_W  = 2,
    parameter int CRED_W = 8,
    parameter int PREG_W = 8,
    parameter int SKID_D = DELAY + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(W+1)-1:0]   grp_cnt,
    input  logic [W-1:0]             grp_squashed,
    input  logic [W*DST_W-1:0]       grp_dst,
    input  logic [CRED_W-1:0]        rob_free,
    input  logic [CRED_W-1:0]        iq_free,
    input  logic [PREG_W-1:0]        preg_free,
    input  logic                     iew_stall,
    input  logic                     cmt_stall,
    input  logic                     squash_req,
    input  logic                     rob_squashing,
    output logic [W-1:0]             dispatch_mask,
    output logic                     stall_up,
    output logic [2:0]               state,
    output logic                     skid_ovf
);
    localparam int CNT_W  = $clog2(W + 1);
    localparam int CRW    = CRED_W + 2;
    localparam int DEDUCT = W * DELAY;
    localparam int GW     = CNT_W + W + W * DST_W;

    rn_state_e        state_q, state_d;
    logic [CNT_W-1:0] idx_q, idx_d;

    logic [GW-1:0]         in_grp, head_grp, src_grp;
    logic                  sk_push, sk_pop, sk_flush, sk_empty, sk_last;
    logic                  use_skid, in_ne, sq_any, stl_any, walk_en;
    logic signed [CRW-1:0] rob_use, iq_use, credit;
    logic [W-1:0]          w_mask;
    logic                  w_short;
    logic [CNT_W-1:0]      w_stop;

    assign in_grp   = {grp_cnt, grp_squashed, grp_dst};
    assign use_skid = (state_q == ST_UNBLOCK);
    assign src_grp  = use_skid ? head_grp : in_grp;
    assign in_ne    = (grp_cnt != '0);
    assign sq_any   = squash_req || rob_squashing;
    assign stl_any  = iew_stall || cmt_stall;
    assign rob_use  = $signed(CRW'(rob_free)) - $signed(CRW'(DEDUCT));
    assign iq_use   = $signed(CRW'(iq_free)) - $signed(CRW'(DEDUCT));
    assign credit   = (rob_use < iq_use) ? rob_use : iq_use;

    rn_skid_fifo #(.GW(GW), .DEPTH(SKID_D)) u_skid (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (sk_flush),
        .push  (sk_push),
        .pop   (sk_pop),
        .din   (in_grp),
        .dout  (head_grp),
        .empty (sk_empty),
        .last  (sk_last),
        .ovf   (skid_ovf)
    );

    rn_slot_walker #(.W(W), .CNT_W(CNT_W), .DST_W(DST_W), .CRW(CRW), .PREG_W(PREG_W)) u_walk (
        .start_idx  (use_skid ? idx_q : '0),
        .cnt        (src_grp[GW-1 -: CNT_W]),
        .squashed   (src_grp[W*DST_W +: W]),
        .dst        (src_grp[W*DST_W-1:0]),
        .credit     (credit),
        .preg       (preg_free),
        .mask       (w_mask),
        .short_stop (w_short),
        .stop_idx   (w_stop)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        sk_push  = 1'b0;
        sk_pop   = 1'b0;
        sk_flush = 1'b0;
        walk_en  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RUN, ST_UNBLOCK: begin
                if (sq_any) begin
                    state_d  = ST_SQUASH;
                    sk_flush = 1'b1;
                    idx_d    = '0;
                end else if (stl_any || (credit <= 0 && (use_skid || in_ne))) begin
                    state_d = ST_BLOCK;
                    sk_push = in_ne;
                end else if (use_skid || in_ne) begin
                    walk_en = 1'b1;
                    if (w_short) begin
                        state_d = ST_BLOCK;
                        idx_d   = w_stop;
                        sk_push = in_ne;
                    end else if (use_skid) begin
                        idx_d   = '0;
                        sk_pop  = 1'b1;
                        sk_push = in_ne;
                        state_d = (sk_last && !in_ne) ? ST_RUN : ST_UNBLOCK;
                    end else begin
                        idx_d   = '0;
                        state_d = ST_RUN;
                    end
                end
            end
            ST_BLOCK: begin
                sk_push = in_ne;
                if (sq_any) begin
                    state_d  = ST_SQUASH;
                    sk_flush = 1'b1;
                    idx_d    = '0;
                end else if (!stl_any && rob_use > 0 && iq_use > 0 && preg_free != '0) begin
                    if (sk_empty && !in_ne) begin
                        state_d = ST_RUN;
                        idx_d   = '0;
                    end else begin
                        state_d = ST_UNBLOCK;
                    end
                end
            end
            ST_SQUASH: begin
                if (sq_any) sk_flush = 1'b1;
                else        state_d  = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign dispatch_mask = walk_en ? w_mask : '0;
    assign stall_up      = (state_q == ST_BLOCK) || (state_q == ST_UNBLOCK);
    assign state         = state_q;
endmodule

// File: rtl/rename_flow_ctrl_chk.sv
module rename_flow_ctrl_chk #(
    parameter int W      = 4,
    parameter int DELAY  = 1,
    parameter int CRED_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      grp_squashed,
    input logic [CRED_W-1:0] rob_free,
    input logic [CRED_W-1:0] iq_free,
    input logic              squash_req,
    input logic              rob_squashing,
    input logic [W-1:0]      dispatch_mask,
    input logic [2:0]        state
);
    localparam int DEDUCT = W * DELAY;

    AST_NO_CREDIT_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rob_free) <= DEDUCT || int'(iq_free) <= DEDUCT) |-> dispatch_mask == '0); // R3

    AST_SQUASHED_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        state != 3'd3 |-> (dispatch_mask & grp_squashed) == '0); // R5

    AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd2 || state == 3'd4) |-> dispatch_mask == '0); // R7

    AST_SQUASH_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_req || rob_squashing) |=> state == 3'd4); // R10

    AST_SQUASH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4 && !squash_req && !rob_squashing) |=> state == 3'd1); // R10
endmodule

bind rename_flow_ctrl rename_flow_ctrl_chk #(.W(W), .DELAY(DELAY), .CRED_W(CRED_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .grp_squashed  (grp_squashed),
    .rob_free      (rob_free),
    .iq_free       (iq_free),
    .squash_req    (squash_req),
    .rob_squashing (rob_squashing),
    .dispatch_mask (dispatch_mask),
    .state         (state)
);

// File: tb/rename_flow_ctrl_test.sv
module rename_flow_ctrl_test;
    localparam int W = 4;
    localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_BLK = 3'd2, S_UNB = 3'd3, S_SQ = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] grp_cnt = '0;
    logic [3:0] grp_squashed = '0;
    logic [7:0] grp_dst = 8'b01_01_01_01;
    logic [7:0] rob_free = 8'd20, iq_free = 8'd20, preg_free = 8'd10;
    logic       iew_stall = 0, cmt_stall = 0, squash_req = 0, rob_squashing = 0;
    logic [3:0] dispatch_mask;
    logic       stall_up, skid_ovf;
    logic [2:0] state;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    rename_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .grp_cnt(grp_cnt), .grp_squashed(grp_squashed),
        .grp_dst(grp_dst), .rob_free(rob_free), .iq_free(iq_free), .preg_free(preg_free),
        .iew_stall(iew_stall), .cmt_stall(cmt_stall), .squash_req(squash_req),
        .rob_squashing(rob_squashing), .dispatch_mask(dispatch_mask), .stall_up(stall_up),
        .state(state), .skid_ovf(skid_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // advance one clock, return at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input int cnt, input logic [3:0] sq, input logic [7:0] dst);
        grp_cnt = 3'(cnt); grp_squashed = sq; grp_dst = dst;
    endtask

    task automatic idle_in();
        drive(0, 4'b0, 8'b01_01_01_01);
        iew_stall = 0; cmt_stall = 0; squash_req = 0; rob_squashing = 0;
        rob_free = 20; iq_free = 20; preg_free = 10;
    endtask

    task automatic t_reset();
        chk("R1 state", state, S_IDLE);
        chk("R1 stall", stall_up, 0);
        chk("R1 mask", dispatch_mask, 0);
        step();
        chk("R1 idle hold", state, S_IDLE);
    endtask

    task automatic t_basic();
        drive(3, 4'b0000, 8'b01_01_01_01); #1;
        chk("R2 mask", dispatch_mask, 4'b0111);
        step(); chk("R2 state", state, S_RUN);
        drive(3, 4'b0010, 8'b01_01_01_01); #1;
        chk("R5 mask", dispatch_mask, 4'b0101);
        step(); idle_in();
    endtask

    task automatic t_partial_replay();
        rob_free = 6; drive(4, 4'b0000, 8'b01_01_01_01); #1;
        chk("R4 mask", dispatch_mask, 4'b0011);
        step(); chk("R4 state", state, S_BLK);
        chk("R7 stall", stall_up, 1);
        rob_free = 20; iew_stall = 1; drive(2, 4'b0000, 8'b01_01_01_01); #1;
        chk("R7 mask", dispatch_mask, 0);
        chk("R11 no ovf", skid_ovf, 0);
        step(); chk("R8 held", state, S_BLK);
        iew_stall = 0; drive(0, 4'b0, 8'b01_01_01_01);
        step(); chk("R8 unblock", state, S_UNB);
        chk("R7 stall unb", stall_up, 1);
        #1; chk("R9 resume idx", dispatch_mask, 4'b1100);
        step(); chk("R9 still unb", state, S_UNB);
        #1; chk("R9 second grp", dispatch_mask, 4'b0011);
        step(); chk("R9 drained", state, S_RUN);
        chk("R7 stall off", stall_up, 0);
    endtask

    task automatic t_credit_edges();
        rob_free = 5; drive(1, 4'b0, 8'b01_01_01_01); #1;
        chk("R3 one credit", dispatch_mask, 4'b0001);
        step(); chk("R3 run", state, S_RUN);
        rob_free = 4; drive(2, 4'b0, 8'b01_01_01_01); #1;
        chk("R3 zero credit", dispatch_mask, 0);
        step(); chk("R3 block", state, S_BLK);
        rob_free = 20; drive(0, 4'b0, 8'b01_01_01_01);
        step(); chk("R8 to unb", state, S_UNB);
        #1; chk("R9 full replay", dispatch_mask, 4'b0011);
        step(); chk("R9 back run", state, S_RUN);
        iq_free = 5; drive(3, 4'b0, 8'b01_01_01_01); #1;
        chk("R3 iq credit", dispatch_mask, 4'b0001);
        step(); chk("R4 iq block", state, S_BLK);
        iq_free = 20; rob_squashing = 1; drive(0, 4'b0, 8'b01_01_01_01);
        step(); chk("R10 rob sq", state, S_SQ);
        chk("R10 stall low", stall_up, 0);
        rob_squashing = 0; step();
        chk("R10 exit", state, S_RUN);
    endtask

    task automatic t_preg();
        preg_free = 2; drive(3, 4'b0, 8'b00_01_10_01); #1;
        chk("R6 mask", dispatch_mask, 4'b0001);
        step(); chk("R6 block", state, S_BLK);
        squash_req = 1; drive(0, 4'b0, 8'b01_01_01_01); preg_free = 10;
        step(); idle_in(); step();
        chk("R10 run", state, S_RUN);
    endtask

    task automatic t_ovf_flush();
        cmt_stall = 1; drive(1, 4'b0, 8'b01_01_01_01); #1;
        chk("R12 mask", dispatch_mask, 0);
        step(); chk("R12 block", state, S_BLK);
        #1; chk("R11 second ok", skid_ovf, 0);
        step(); #1;
        chk("R11 ovf", skid_ovf, 1);
        squash_req = 1; #1;
        chk("R10 flush mask", dispatch_mask, 0);
        step(); chk("R10 sq", state, S_SQ);
        cmt_stall = 0; drive(2, 4'b0, 8'b01_01_01_01); step();
        chk("R10 hold", state, S_SQ);
        squash_req = 0; drive(0, 4'b0, 8'b01_01_01_01); step();
        chk("R10 run", state, S_RUN);
        iew_stall = 1; step();
        chk("R12 blk empty", state, S_BLK);
        iew_stall = 0; step();
        chk("R8 flushed direct run", state, S_RUN);
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        #1;
        t_reset();
        t_basic();
        t_partial_replay();
        t_credit_edges();
        t_preg();
        t_ovf_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule